// File: doc/BRIEF.md
# Cable thermal shutdown monitor

This block sits beside the marker controller in an active cable plug. It takes digital readings from the plug temperature sensor, keeps the current internal temperature in whole degrees Celsius, and estimates the skin temperature by subtracting a programmable internal-to-skin offset. It compares that estimate with a trip level that the housing strap selects. A metal housing trips lower than a plastic or rubber one.

When the estimate reaches the trip level, the block latches a shutdown flag for the cable status response. While the flag is set, it requests that the high-speed lanes go to their disabled state. The flag can only be cleared by an explicit clear, and only once the estimate has fallen 5 °C below the trip level. A fixed maximum internal operating temperature is also presented for the identity response.

Top module: `cable_thermal_guard`

## Requirements
- R1: A sensor code is captured only on a clock edge where `sens_valid_i` is high. `cur_temp_o` then equals the captured code, and it does not change on any edge where `sens_valid_i` is low.
- R2: The skin estimate is the captured code minus `skin_offset_i`, saturated at 0. A code below the offset therefore never trips.
- R3: The trip level is 80 when `housing_metal_i` is 0 (plastic or rubber) and 55 when it is 1 (metal), lowered by the parameter `TRIP_DERATE` (default 0). A trip occurs when the estimate is greater than or equal to the trip level.
- R4: The compare runs one cycle after capture. `thermal_shut_o` is still 0 after the capturing edge and rises after the following edge.
- R5: Once set, `thermal_shut_o` stays 1 until `shut_clear_i` is high on an edge where the latest estimate is below the trip level minus 5. A clear at any other time has no effect.
- R6: `ss_disable_o` is 1 exactly while `thermal_shut_o` is 1.
- R7: `max_op_temp_o` always shows the parameter `MAX_OP_TEMP` (default 100).
- R8: After reset, `thermal_shut_o`, `ss_disable_o` and `cur_temp_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sens_code_i | input | 8 | Sensor reading, degrees Celsius |
| sens_valid_i | input | 1 | Sensor reading strobe |
| housing_metal_i | input | 1 | Housing strap: 1 = metal, 0 = plastic or rubber |
| skin_offset_i | input | 8 | Internal-to-skin offset, degrees Celsius |
| shut_clear_i | input | 1 | Request to clear the shutdown flag |
| cur_temp_o | output | 8 | Current internal temperature |
| max_op_temp_o | output | 8 | Maximum internal operating temperature |
| thermal_shut_o | output | 1 | Latched thermal shutdown status flag |
| ss_disable_o | output | 1 | Request to disable the high-speed lanes |

## Verification
The hardest case to reach is the release window: the flag must first be latched by a hot sample, and the estimate must then be pulled back below the trip level. The stimulus lands once just inside the hysteresis band and once just below it, so that a clear is refused and then accepted. The stimulus also covers a clear with no new sample while the last estimate is still hot. Saturation is reached with an offset larger than the code, which would wrap to a hot value if the subtraction were done without saturation.

// File: rtl/cable_thermal_guard.sv
module cable_thermal_guard #(
  parameter int TW          = 8,
  parameter int PLASTIC_MAX = 80,
  parameter int METAL_MAX   = 55,
  parameter int TRIP_DERATE = 0,
  parameter int HYST        = 5,
  parameter int MAX_OP_TEMP = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] sens_code_i,
  input  logic          sens_valid_i,
  input  logic          housing_metal_i,
  input  logic [TW-1:0] skin_offset_i,
  input  logic          shut_clear_i,
  output logic [TW-1:0] cur_temp_o,
  output logic [TW-1:0] max_op_temp_o,
  output logic          thermal_shut_o,
  output logic          ss_disable_o
);
  localparam logic [TW-1:0] TRIP_PL = TW'(PLASTIC_MAX - TRIP_DERATE);
  localparam logic [TW-1:0] TRIP_MT = TW'(METAL_MAX - TRIP_DERATE);
  localparam logic [TW-1:0] REL_PL  = TW'(PLASTIC_MAX - TRIP_DERATE - HYST);
  localparam logic [TW-1:0] REL_MT  = TW'(METAL_MAX - TRIP_DERATE - HYST);

  logic [TW-1:0] skin_q, trip_lvl, rel_lvl;
  logic [TW:0]   diff;
  logic          cmp_q, shut_q;

  assign diff     = {1'b0, sens_code_i} - {1'b0, skin_offset_i};
  assign trip_lvl = housing_metal_i ? TRIP_MT : TRIP_PL;
  assign rel_lvl  = housing_metal_i ? REL_MT : REL_PL;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_temp_o <= '0;
      skin_q     <= '0;
      cmp_q      <= 1'b0;
    end else begin
      cmp_q <= sens_valid_i;
      if (sens_valid_i) begin
        cur_temp_o <= sens_code_i;
        skin_q     <= diff[TW] ? '0 : diff[TW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shut_q <= 1'b0;
    else if (cmp_q && skin_q >= trip_lvl)
      shut_q <= 1'b1;
    else if (shut_clear_i && skin_q < rel_lvl)
      shut_q <= 1'b0;
  end

  assign thermal_shut_o = shut_q;
  assign ss_disable_o   = shut_q;
  assign max_op_temp_o  = TW'(MAX_OP_TEMP);
endmodule

module cable_thermal_guard_chk #(parameter int TW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          sens_valid_i,
  input logic          shut_clear_i,
  input logic [TW-1:0] cur_temp_o,
  input logic [TW-1:0] skin_q,
  input logic [TW-1:0] trip_lvl,
  input logic [TW-1:0] rel_lvl,
  input logic          cmp_q,
  input logic          thermal_shut_o
);
  a_r1_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !sens_valid_i |=> $stable(cur_temp_o));
  a_r2_skin_not_above_code: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_q |-> skin_q <= cur_temp_o);
  a_r4_trip_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_q && skin_q >= trip_lvl) |=> thermal_shut_o);
  a_r5_sticky_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (thermal_shut_o && !shut_clear_i) |=> thermal_shut_o);
  a_r5_sticky_while_warm: assert property (@(posedge clk) disable iff (!rst_n)
    (thermal_shut_o && skin_q >= rel_lvl) |=> thermal_shut_o);
endmodule

bind cable_thermal_guard cable_thermal_guard_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sens_valid_i(sens_valid_i), .shut_clear_i(shut_clear_i),
  .cur_temp_o(cur_temp_o), .skin_q(skin_q), .trip_lvl(trip_lvl), .rel_lvl(rel_lvl),
  .cmp_q(cmp_q), .thermal_shut_o(thermal_shut_o)
);

// File: tb/cable_thermal_guard_tb.sv
module cable_thermal_guard_tb;
  logic clk = 0, rst_n = 0;
  logic [7:0] code = 0, off = 0;
  logic valid = 0, metal = 0, clr = 0;
  logic [7:0] cur, maxop;
  logic shut, dis;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  cable_thermal_guard u_dut (
    .clk(clk), .rst_n(rst_n), .sens_code_i(code), .sens_valid_i(valid),
    .housing_metal_i(metal), .skin_offset_i(off), .shut_clear_i(clr),
    .cur_temp_o(cur), .max_op_temp_o(maxop), .thermal_shut_o(shut), .ss_disable_o(dis)
  );

  // {metal, offset, code, expected trip}
  localparam logic [17:0] VEC [0:7] = '{
    {1'b0, 8'd0,  8'd79,  1'b0},
    {1'b0, 8'd0,  8'd80,  1'b1},
    {1'b0, 8'd10, 8'd89,  1'b0},
    {1'b0, 8'd10, 8'd90,  1'b1},
    {1'b1, 8'd0,  8'd54,  1'b0},
    {1'b1, 8'd0,  8'd55,  1'b1},
    {1'b1, 8'd20, 8'd10,  1'b0},
    {1'b0, 8'd0,  8'd255, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    @(negedge clk) rst_n = 1;
  endtask

  task automatic push(input logic [7:0] c);
    @(negedge clk) begin code = c; valid = 1; end
    @(negedge clk) valid = 0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R8 shut", shut, 0);
    chk("R8 disable", dis, 0);
    chk("R8 temp", cur, 0);
    chk("R7 max op", maxop, 100);

    for (int i = 0; i < 8; i++) begin
      do_reset();
      metal = VEC[i][17];
      off = VEC[i][16:9];
      push(VEC[i][8:1]);
      chk("R4 not yet", shut, 0);
      @(negedge clk);
      chk("R1 cur temp", cur, VEC[i][8:1]);
      chk("R2/R3 trip", shut, VEC[i][0]);
      chk("R6 disable", dis, VEC[i][0]);
    end

    // R1: no strobe, no capture
    do_reset();
    metal = 0; off = 0;
    push(8'd40);
    @(negedge clk) code = 8'd99;
    @(negedge clk);
    chk("R1 hold", cur, 40);
    chk("R1 no trip", shut, 0);

    // R5: trip, then clear refused while warm, then accepted
    push(8'd85);
    @(negedge clk);
    chk("R5 set", shut, 1);
    push(8'd75);
    @(negedge clk);
    chk("R5 no clear given", shut, 1);
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    chk("R5 clear at 75 refused", shut, 1);
    chk("R6 disable held", dis, 1);
    push(8'd74);
    @(negedge clk);
    chk("R5 still set w/o clear", shut, 1);
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    chk("R5 clear at 74", shut, 0);
    chk("R6 disable drop", dis, 0);

    // R5: clear while still hot has no effect; metal release at 49
    metal = 1;
    push(8'd60);
    @(negedge clk);
    chk("R3 metal trip", shut, 1);
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    chk("R5 hot clear ignored", shut, 1);
    push(8'd50);
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    chk("R5 metal 50 refused", shut, 1);
    push(8'd49);
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    chk("R5 metal 49 clear", shut, 0);
    chk("R7 max op", maxop, 100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule